// File: doc/BRIEF.md
# Pipelined AES-128 Encryption Core

This block encrypts 128-bit blocks with AES-128 in a fully unrolled pipeline. Each of the ten rounds has its own datapath and its own register stage. A new plaintext can enter on every clock, and up to ten unrelated blocks are in flight at once, one per stage. Once the pipeline has filled, one ciphertext leaves on every clock. This suits counter-style use, where successive blocks do not depend on one another.

The eleven round keys are not derived inside the block. The host expands the cipher key and writes the round keys one at a time into a small key file. A write is accepted only while the pipeline is empty, and a status output shows when that is the case.

Every block carries a valid bit and a short tag alongside it through the stages. The tag is returned with the ciphertext, so each result can be matched to the request that produced it. There is no back-pressure.

Top module: `aes128_pipe`

## Requirements
- R1: With round keys 0..10 of an AES-128 key schedule held in key slots 0..10, the output for an accepted plaintext is its AES-128 ciphertext. The byte at bits [127:120] is the first byte of the state (row 0, column 0), and the bytes fill the state column by column.
- R2: A block accepted at a rising edge (in_valid high) appears with out_valid high after exactly the tenth following rising edge, counting the accepting edge as the first.
- R3: Blocks may be accepted on consecutive cycles without limit. Results leave in acceptance order, one per cycle, with no loss.
- R4: The out_tag returned with each result equals the in_tag presented with that block.
- R5: out_valid is low in every cycle that does not correspond, by the latency of R2, to an accepted block. Idle input cycles give idle output cycles.
- R6: pipe_empty is high exactly when no accepted block is still inside the pipeline. It goes low in the cycle after an accept, and high again one cycle after the last result has been presented.
- R7: A key write (key_we high) changes slot key_sel only if pipe_empty is high and in_valid is low in that same cycle. Otherwise the key file is left unchanged.
- R8: A key write with key_sel greater than 10 changes no slot.
- R9: While rst_n is low, out_valid is low and pipe_empty is high. Reset also drops every block in flight and clears the key file to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| key_we | input | 1 | Round key write strobe |
| key_sel | input | 4 | Round key slot index, 0..10 |
| key_word | input | 128 | Round key value to write |
| in_valid | input | 1 | Plaintext present this cycle |
| in_data | input | 128 | Plaintext block |
| in_tag | input | TAG_W | Request tag travelling with the block |
| out_valid | output | 1 | Ciphertext present this cycle |
| out_data | output | 128 | Ciphertext block |
| out_tag | output | TAG_W | Tag of the returned block |
| pipe_empty | output | 1 | No block in flight |

## Verification
A key write and the entry or passage of a block can fall in the same cycle. The bench provokes this in two ways: it writes a bogus round key while blocks are still in the stages, and it raises key_we together with in_valid on an otherwise empty pipeline. The attempt is judged ignored only if the blocks in flight, and a known-answer block sent after the pipeline drains, still produce correct ciphertext. Separately, randomly gapped streams under two keys are compared against a behavioural model in the bench for data, tag, order and exact output cycle.

// File: rtl/aes128_pipe.sv
module aes128_pipe #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_we,
  input  logic [3:0]       key_sel,
  input  logic [127:0]     key_word,
  input  logic             in_valid,
  input  logic [127:0]     in_data,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  output logic [127:0]     out_data,
  output logic [TAG_W-1:0] out_tag,
  output logic             pipe_empty
);
  localparam int NR = 10;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x, y;
    p = 8'h00; x = a; y = b;
    for (int i = 0; i < 8; i++) begin
      if (y[0]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
      y = {1'b0, y[7:1]};
    end
    return p;
  endfunction

  function automatic logic [7:0] sub_byte(input logic [7:0] a);
    logic [7:0] t, r;
    t = a; r = 8'h01;
    for (int k = 1; k < 8; k++) begin
      t = gf_mul(t, t);
      r = gf_mul(r, t);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^ {r[3:0], r[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [127:0] round_fn(input logic [127:0] s, input logic [127:0] k,
                                            input logic mix);
    logic [7:0] b [16];
    logic [7:0] h [16];
    logic [7:0] m [16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) b[i] = sub_byte(s[127-8*i -: 8]);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        h[4*c+r] = b[4*((c+r)%4)+r];
    for (int c = 0; c < 4; c++) begin
      if (mix) begin
        m[4*c+0] = gf_mul(h[4*c], 8'h02) ^ gf_mul(h[4*c+1], 8'h03) ^ h[4*c+2] ^ h[4*c+3];
        m[4*c+1] = h[4*c] ^ gf_mul(h[4*c+1], 8'h02) ^ gf_mul(h[4*c+2], 8'h03) ^ h[4*c+3];
        m[4*c+2] = h[4*c] ^ h[4*c+1] ^ gf_mul(h[4*c+2], 8'h02) ^ gf_mul(h[4*c+3], 8'h03);
        m[4*c+3] = gf_mul(h[4*c], 8'h03) ^ h[4*c+1] ^ h[4*c+2] ^ gf_mul(h[4*c+3], 8'h02);
      end else begin
        for (int r = 0; r < 4; r++) m[4*c+r] = h[4*c+r];
      end
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = m[i];
    return o ^ k;
  endfunction

  logic [NR:0][127:0]  rk;
  logic [127:0]        st  [1:NR];
  logic [TAG_W-1:0]    tg  [1:NR];
  logic [NR:1]         vld;
  logic                key_ok;

  assign pipe_empty = ~|vld;
  assign key_ok     = key_we && pipe_empty && !in_valid && (key_sel <= 4'(NR));

  always_ff @(posedge clk) begin
    if (!rst_n) rk <= '0;
    else if (key_ok) rk[key_sel] <= key_word;
  end

  genvar g;
  generate
    for (g = 1; g <= NR; g++) begin : g_stage
      logic [127:0] d_in;
      if (g == 1) begin : g_first
        assign d_in = in_data ^ rk[0];
        always_ff @(posedge clk) begin
          if (!rst_n) vld[g] <= 1'b0;
          else        vld[g] <= in_valid;
          st[g] <= round_fn(d_in, rk[g], 1'b1);
          tg[g] <= in_tag;
        end
      end else begin : g_rest
        assign d_in = st[g-1];
        always_ff @(posedge clk) begin
          if (!rst_n) vld[g] <= 1'b0;
          else        vld[g] <= vld[g-1];
          st[g] <= round_fn(d_in, rk[g], g != NR);
          tg[g] <= tg[g-1];
        end
      end
    end
  endgenerate

  assign out_valid = vld[NR];
  assign out_data  = st[NR];
  assign out_tag   = tg[NR];

  AST_LATENCY:   assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(in_valid, 10)); // R2
  AST_TAG_ORDER: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> out_tag == $past(in_tag, 10)); // R4
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) pipe_empty |-> !out_valid); // R6
  AST_FILL:      assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> !pipe_empty); // R6
  AST_KEY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (!pipe_empty || in_valid) |=> $stable(rk)); // R7
  AST_KEY_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (key_sel > 4'd10) |=> $stable(rk)); // R8
endmodule

// File: tb/tb_aes128_pipe.sv
module tb_aes128_pipe;
  localparam int TAG_W = 8;
  // key, plaintext, ciphertext (known answers)
  localparam logic [383:0] KAT [2] = '{
    {128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
     128'h69c4e0d86a7b0430d8cdb78070b4c55a},
    {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
     128'h3925841d02dc09fbdc118597196a0b32}
  };

  logic clk = 0, rst_n = 0;
  logic key_we = 0; logic [3:0] key_sel = 0; logic [127:0] key_word = 0;
  logic in_valid = 0; logic [127:0] in_data = 0; logic [TAG_W-1:0] in_tag = 0;
  logic out_valid; logic [127:0] out_data; logic [TAG_W-1:0] out_tag; logic pipe_empty;

  aes128_pipe #(.TAG_W(TAG_W)) dut (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_sel(key_sel), .key_word(key_word),
    .in_valid(in_valid), .in_data(in_data), .in_tag(in_tag),
    .out_valid(out_valid), .out_data(out_data), .out_tag(out_tag), .pipe_empty(pipe_empty));

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic [7:0]   sbx [256];
  logic [127:0] cur_rk [11];
  logic [127:0] exp_ct [1024];
  logic [TAG_W-1:0] exp_tg [1024];
  int exp_cy [1024];
  string exp_rq [1024];
  int wr = 0, rd = 0;
  logic [TAG_W-1:0] tag_ctr = 0;

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] ex);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, ex);
    end
  endtask

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    for (int i = 7; i >= 0; i--) begin
      p = xt(p);
      if (b[i]) p ^= a;
    end
    return p;
  endfunction

  function automatic void expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sbx[t[23:16]], sbx[t[15:8]], sbx[t[7:0]], sbx[t[31:24]]} ^ {rc, 24'h0};
        rc = xt(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) cur_rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endfunction

  function automatic logic [127:0] model(input logic [127:0] pt);
    logic [7:0] s [16];
    logic [7:0] n [16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ cur_rk[0][127-8*i -: 8];
    for (int r = 1; r <= 10; r++) begin
      for (int i = 0; i < 16; i++) n[i] = sbx[s[(4*((i/4)+(i%4)) + (i%4)) % 16]];
      for (int c = 0; c < 4 && r < 10; c++) begin
        logic [7:0] a0, a1, a2, a3;
        a0 = n[4*c]; a1 = n[4*c+1]; a2 = n[4*c+2]; a3 = n[4*c+3];
        n[4*c]   = mul(a0,2) ^ mul(a1,3) ^ a2 ^ a3;
        n[4*c+1] = a0 ^ mul(a1,2) ^ mul(a2,3) ^ a3;
        n[4*c+2] = a0 ^ a1 ^ mul(a2,2) ^ mul(a3,3);
        n[4*c+3] = mul(a0,3) ^ a1 ^ a2 ^ mul(a3,2);
      end
      for (int i = 0; i < 16; i++) s[i] = n[i] ^ cur_rk[r][127-8*i -: 8];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  task automatic tick();
    bit due;
    @(negedge clk);
    cyc++;
    due = (rd < wr) && (exp_cy[rd] == cyc);
    if (due) chk(out_valid == 1'b1, "R2", {127'h0, out_valid}, 128'h1);
    else if (out_valid) chk(1'b0, "R5", {127'h0, out_valid}, 128'h0);
    if (due) begin
      if (out_valid) begin
        chk(out_data == exp_ct[rd], exp_rq[rd], out_data, exp_ct[rd]);
        chk(out_tag == exp_tg[rd], "R4", {120'h0, out_tag}, {120'h0, exp_tg[rd]});
      end
      rd++;
    end
  endtask

  task automatic send(input logic [127:0] pt, input string rq);
    in_valid = 1; in_data = pt; in_tag = tag_ctr;
    exp_ct[wr] = model(pt); exp_tg[wr] = tag_ctr; exp_cy[wr] = cyc + 10; exp_rq[wr] = rq;
    wr++; tag_ctr++;
    tick();
    in_valid = 0;
  endtask

  task automatic drain();
    in_valid = 0;
    while (!pipe_empty) tick();
  endtask

  task automatic load_keys(input logic [127:0] key);
    drain();
    expand(key);
    for (int r = 0; r < 11; r++) begin
      key_we = 1; key_sel = 4'(r); key_word = cur_rk[r];
      tick();
    end
    key_we = 0;
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin
      logic [7:0] inv = 0, r;
      for (int b = 1; b < 256; b++) if (mul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
      r = inv;
      sbx[a] = r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^ {r[3:0], r[7:4]} ^ 8'h63;
    end

    tick(); tick();
    chk(out_valid == 0, "R9", {127'h0, out_valid}, 0);
    chk(pipe_empty == 1, "R9", {127'h0, pipe_empty}, 1);
    rst_n = 1;
    tick();

    // known-answer table
    for (int v = 0; v < 2; v++) begin
      load_keys(KAT[v][383:256]);
      chk(model(KAT[v][255:128]) == KAT[v][127:0], "R1", model(KAT[v][255:128]), KAT[v][127:0]);
      send(KAT[v][255:128], "R1");
      drain();
      chk(rd == wr, "R1", 128'(rd), 128'(wr));
    end

    // pipe_empty timing around one block (R6)
    send(KAT[1][255:128], "R1");
    chk(pipe_empty == 0, "R6", {127'h0, pipe_empty}, 0);
    for (int i = 0; i < 9; i++) tick();
    chk(out_valid == 1 && pipe_empty == 0, "R6", {126'h0, out_valid, pipe_empty}, 128'h2);
    tick();
    chk(pipe_empty == 1, "R6", {127'h0, pipe_empty}, 1);

    // back-to-back full stream (R3)
    for (int i = 0; i < 40; i++) send({$urandom, $urandom, $urandom, $urandom}, "R3");
    drain();
    chk(rd == wr, "R3", 128'(rd), 128'(wr));

    // random gaps under a fresh key
    load_keys({$urandom, $urandom, $urandom, $urandom});
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 3 == 0) tick();
      else send({$urandom, $urandom, $urandom, $urandom}, "R1");
    end
    drain();
    chk(rd == wr, "R5", 128'(rd), 128'(wr));

    // key writes that must be ignored (R7)
    load_keys(KAT[0][383:256]);
    send(KAT[0][255:128], "R7");
    send(KAT[0][255:128] ^ 128'h1, "R7");
    key_we = 1; key_sel = 4'd3; key_word = '1;
    tick(); tick();
    key_we = 0;
    drain();
    key_we = 1; key_sel = 4'd0; key_word = '1;
    send(KAT[0][255:128], "R7");
    key_we = 0;
    drain();
    send(KAT[0][255:128], "R7");
    drain();
    chk(exp_ct[wr-1] == KAT[0][127:0], "R7", exp_ct[wr-1], KAT[0][127:0]);

    // out-of-range slots (R8)
    for (int s = 11; s < 16; s++) begin
      key_we = 1; key_sel = 4'(s); key_word = 128'hdeadbeef;
      tick();
    end
    key_we = 0;
    send(KAT[0][255:128], "R8");
    drain();

    // reset with blocks in flight (R9)
    send(KAT[0][255:128], "R9"); send(KAT[0][255:128], "R9"); send(KAT[0][255:128], "R9");
    tick();
    rst_n = 0;
    rd = wr;
    tick();
    chk(out_valid == 0, "R9", {127'h0, out_valid}, 0);
    chk(pipe_empty == 1, "R9", {127'h0, pipe_empty}, 1);
    for (int i = 0; i < 12; i++) begin
      tick();
      if (out_valid) chk(1'b0, "R9", 1, 0);
    end
    rst_n = 1;
    tick();
    load_keys(KAT[1][383:256]);
    send(KAT[1][255:128], "R9");
    drain();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule